// File: doc/BRIEF.md
# Two-Channel Constant-Current Chopper with Latched Protection

This block is the digital core of a two-winding stepper power stage. A free-running timebase opens a fixed-length chopping period for each winding. Winding B's period starts a set number of cycles after winding A's, so the two sides never switch on together. At the start of its period a channel lets its requested phase drives through. It blocks them again, for the rest of that period, once its current comparator reports that the coil has reached the set level. The comparators, the reference divider, the sense resistor and the power switches stay outside the block and appear only as single-bit pins.

Protection is latched. An overcurrent report counts only outside a blanking window that follows every turn-on, because switching ringing would otherwise trip it. An overheat report counts at any time. Either latch forces all four drive pins low, pulls the shared fault pin low and drives a two-level code that tells the cause. The latches clear only on power-on reset or when the reset-request pin returns high after being low. A low enable freezes the timebase, the channels and the latches, and holds the drives off.

There is no data stream here, so no valid/ready handshake is used. Every pin is a plain level control or status signal. The defaults assume a 100 MHz clock: a 2000-cycle period gives 50 kHz, and a 125-cycle window gives 1.25 µs.

Top module: `coil_chopper`

## Requirements
- R1: While enable is high, channel A starts a new period every PERIOD_CYC clock cycles. Its drives, `drive[1:0]`, can be high from the cycle after the start.
- R2: Channel B starts PHASE_OFS cycles after channel A in every period. Its drives, `drive[3:2]`, rise PHASE_OFS cycles after channel A's.
- R3: The comparator input passes through two flip-flops. Once the channel sees it high, the channel stays off until its next period start, so it gives at most one on-pulse per period.
- R4: `drive[1:0]` equals `phase_req[1:0]` while channel A is on and no fault is latched, and is 0 otherwise. `drive[3:2]` follows `phase_req[3:2]` in the same way for channel B.
- R5: An overcurrent report is ignored when it is seen, after its two-flop synchronizer, within the blanking window. The window is a channel's start cycle plus the BLANK_CYC cycles after it.
- R6: An overcurrent report seen outside the window latches. All four drives go to 0, `fault_n` goes to 0 and `fault_code` becomes 2'b01.
- R7: An overheat report latches at any time. All drives go to 0, `fault_n` goes to 0 and `fault_code` becomes 2'b10. When both latches are set, the code is 2'b10.
- R8: The latches clear when `reset_req_n` rises after being low, or on `rst_n`. Holding `reset_req_n` low does not clear them.
- R9: While enable is low, all drives are 0. The timebase, the channel states and the fault latches hold their values, so a later period start is delayed by the number of low cycles, and fault inputs seen during that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req_n | input | 1 | External fault-clear request, active low, acts on its return high |
| enable | input | 1 | High runs the block; low forces the drives off and freezes state |
| phase_req | input | 4 | Requested phase pattern: [1:0] winding A pair, [3:2] winding B pair |
| cmp_a | input | 1 | Winding A current at set level (asynchronous) |
| cmp_b | input | 1 | Winding B current at set level (asynchronous) |
| ovc_in | input | 1 | Overcurrent detector (asynchronous) |
| ovh_in | input | 1 | Overheat detector (asynchronous) |
| drive | output | 4 | Gated phase drives to the power stage |
| fault_n | output | 1 | Low while any fault is latched |
| fault_code | output | 2 | 00 none, 01 overcurrent, 10 overheat |

## Verification
A wrong counter state shows up as a drive rise at the wrong spacing within one period, either between consecutive A rises or between an A rise and the following B rise. A channel that fails to hold off shows a second drive pulse in the same period. A wrong blanking count shows up as a fault latch that fires, or fails to fire, three cycles after an overcurrent pulse placed on the window edge. A latch that clears early or stays stuck shows on `fault_n` and `fault_code` within three cycles of the reset request returning high.

// File: rtl/coil_chopper_pkg.sv
package coil_chopper_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_OVC  = 2'b01,
    FLT_OVH  = 2'b10
  } flt_code_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/cc_sync2.sv
module cc_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cc_timebase.sv
module cc_timebase #(
  parameter int unsigned PERIOD_CYC = 2000,
  parameter int unsigned PHASE_OFS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic start_a,
  output logic start_b
);
  localparam int unsigned CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] OFS  = CNT_W'(PHASE_OFS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (en) begin
      if (cnt == LAST)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assign start_a = en && (cnt == '0);
  assign start_b = en && (cnt == OFS);

  // R9: a frozen timebase keeps its count
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  // R1: the period wraps after its last count
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/cc_chop_channel.sv
module cc_chop_channel #(
  parameter int unsigned BLANK_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic cmp_s,
  output logic on_q,
  output logic blanking
);
  localparam int unsigned BL_W = $clog2(BLANK_CYC + 1);

  logic [BL_W-1:0] blank_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q      <= 1'b0;
      blank_cnt <= '0;
    end else if (en) begin
      if (start) begin
        on_q      <= 1'b1;
        blank_cnt <= BL_W'(BLANK_CYC);
      end else begin
        if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
        if (on_q && cmp_s)   on_q <= 1'b0;
      end
    end
  end

  assign blanking = start || (blank_cnt != '0);

  // R3: a channel only switches on at its period start
  a_r3_on_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> $past(start));
  // R3: once tripped, a channel stays off until the next start
  a_r3_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && cmp_s && !start && en) |=> !on_q);
endmodule

// File: rtl/cc_fault_latch.sv
module cc_fault_latch
  import coil_chopper_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      clear,
  input  logic      mask,
  input  logic      ovc_s,
  input  logic      ovh_s,
  output logic      fault_any,
  output flt_code_e code
);
  logic oc_q, oh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0;
      oh_q <= 1'b0;
    end else if (clear) begin
      oc_q <= 1'b0;
      oh_q <= 1'b0;
    end else if (en) begin
      if (ovc_s && !mask) oc_q <= 1'b1;
      if (ovh_s)          oh_q <= 1'b1;
    end
  end

  assign fault_any = oc_q || oh_q;

  always_comb begin
    if (oh_q)      code = FLT_OVH;
    else if (oc_q) code = FLT_OVC;
    else           code = FLT_NONE;
  end

  // R8: latches hold until a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((oc_q || oh_q) && !clear) |=> (oc_q || oh_q));
  // R5: a masked overcurrent never sets the latch
  a_r5_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_q && mask && !clear) |=> !oc_q);
  // R7: the code never reports two causes
  a_r7_code: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code));
endmodule

// File: rtl/coil_chopper.sv
module coil_chopper
  import coil_chopper_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 2000,
  parameter int unsigned PHASE_OFS  = 1000,
  parameter int unsigned BLANK_CYC  = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req_n,
  input  logic       enable,
  input  logic [3:0] phase_req,
  input  logic       cmp_a,
  input  logic       cmp_b,
  input  logic       ovc_in,
  input  logic       ovh_in,
  output logic [3:0] drive,
  output logic       fault_n,
  output logic [1:0] fault_code
);
  logic [3:0]        raw_in, syn_in;
  logic              rr_s, rr_prev, clear;
  logic [NUM_CH-1:0] start, on_ch, blank_ch, cmp_s;
  logic              fault_any;
  flt_code_e         code;

  assign raw_in = {ovh_in, ovc_in, cmp_b, cmp_a};

  cc_sync2 #(.W(4), .RST_VAL(1'b0)) u_sync_in (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

  cc_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync_rr (
    .clk(clk), .rst_n(rst_n), .d(reset_req_n), .q(rr_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_prev <= 1'b1;
    else        rr_prev <= rr_s;
  end
  assign clear = rr_s && !rr_prev;

  assign cmp_s = syn_in[1:0];

  cc_timebase #(.PERIOD_CYC(PERIOD_CYC), .PHASE_OFS(PHASE_OFS)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(enable),
    .start_a(start[0]), .start_b(start[1]));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cc_chop_channel #(.BLANK_CYC(BLANK_CYC)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(enable),
      .start(start[g]), .cmp_s(cmp_s[g]),
      .on_q(on_ch[g]), .blanking(blank_ch[g]));
    assign drive[2*g +: 2] = (enable && on_ch[g] && !fault_any)
                             ? phase_req[2*g +: 2] : 2'b00;
  end

  cc_fault_latch u_flt (
    .clk(clk), .rst_n(rst_n), .en(enable), .clear(clear),
    .mask(|blank_ch), .ovc_s(syn_in[2]), .ovh_s(syn_in[3]),
    .fault_any(fault_any), .code(code));

  assign fault_n    = !fault_any;
  assign fault_code = code;

  // R6: a newly latched fault removes every drive in the next cycle
  a_r6_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_any) |-> (drive == 4'b0000));
endmodule

// File: tb/coil_chopper_tb_top.sv
module coil_chopper_tb_top;
  localparam int P = 40;
  localparam int O = 20;
  localparam int B = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req_n = 1'b1, enable = 1'b0;
  logic [3:0] phase_req = 4'b0000;
  logic cmp_a = 1'b0, cmp_b = 1'b0, ovc_in = 1'b0, ovh_in = 1'b0;
  logic [3:0] drive;
  logic fault_n;
  logic [1:0] fault_code;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  coil_chopper #(.PERIOD_CYC(P), .PHASE_OFS(O), .BLANK_CYC(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req_n(reset_req_n), .enable(enable),
    .phase_req(phase_req), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .ovc_in(ovc_in), .ovh_in(ovh_in),
    .drive(drive), .fault_n(fault_n), .fault_code(fault_code));

  // requirement-level timing model
  int   m_cnt;
  logic [3:0] m_s1, m_s2;
  logic m_r1, m_r2, m_rp;
  logic [1:0] m_on;
  int   m_bl [2];
  logic m_oc, m_oh;

  function automatic logic m_mask();
    return (m_cnt == 0) || (m_cnt == O) || (m_bl[0] != 0) || (m_bl[1] != 0);
  endfunction

  function automatic logic [3:0] exp_drive();
    if (!enable || m_oc || m_oh) return 4'b0000;
    return phase_req & {m_on[1], m_on[1], m_on[0], m_on[0]};
  endfunction

  function automatic logic [1:0] exp_code();
    return m_oh ? 2'b10 : (m_oc ? 2'b01 : 2'b00);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_s1 <= '0; m_s2 <= '0;
      m_r1 <= 1'b1; m_r2 <= 1'b1; m_rp <= 1'b1;
      m_on <= '0; m_bl[0] <= 0; m_bl[1] <= 0; m_oc <= 1'b0; m_oh <= 1'b0;
    end else begin
      m_s1 <= {ovh_in, ovc_in, cmp_b, cmp_a};
      m_s2 <= m_s1;
      m_r1 <= reset_req_n; m_r2 <= m_r1; m_rp <= m_r2;
      if (enable) begin
        m_cnt <= (m_cnt == P - 1) ? 0 : m_cnt + 1;
        for (int c = 0; c < 2; c++) begin
          if (m_cnt == (c == 0 ? 0 : O)) begin
            m_on[c] <= 1'b1; m_bl[c] <= B;
          end else begin
            if (m_bl[c] != 0) m_bl[c] <= m_bl[c] - 1;
            if (m_on[c] && m_s2[c]) m_on[c] <= 1'b0;
          end
        end
      end
      if (m_r2 && !m_rp) begin
        m_oc <= 1'b0; m_oh <= 1'b0;
      end else if (enable) begin
        if (m_s2[2] && !m_mask()) m_oc <= 1'b1;
        if (m_s2[3]) m_oh <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R4 drive vs model", {4'b0, drive}, {4'b0, exp_drive()});
      chk("R6 fault_n vs model", {7'b0, fault_n}, {7'b0, !(m_oc || m_oh)});
      chk("R7 code vs model", {6'b0, fault_code}, {6'b0, exp_code()});
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    @(negedge clk);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic pulse_reset_req(input int low_cycles);
    reset_req_n = 1'b0;
    cyc(low_cycles);
    chk("R8 held low keeps fault", {7'b0, fault_n}, 8'h00);
    reset_req_n = 1'b1;
    cyc(4);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int ta0, ta1, tb0, hi_a, t;
    logic pa;
    void'($urandom(32'd20240611));

    cyc(3);
    chk("R4 reset drive", {4'b0, drive}, 8'h00);
    chk("R6 reset fault_n", {7'b0, fault_n}, 8'h01);
    chk("R7 reset code", {6'b0, fault_code}, 8'h00);
    rst_n = 1'b1;
    enable = 1'b1;
    cmp_on = 1'b1;

    // random normal operation, no faults
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) phase_req = 4'($urandom);
      cmp_a = ($urandom_range(0, 9) == 0);
      cmp_b = ($urandom_range(0, 9) == 0);
      enable = ($urandom_range(0, 29) != 0);
    end
    enable = 1'b1;

    // directed: period, offset, single pulse (R1 R2 R3)
    phase_req = 4'b0101; cmp_a = 1'b1; cmp_b = 1'b1;
    cyc(2 * P);
    ta0 = -1; ta1 = -1; tb0 = -1; hi_a = 0; pa = drive[0];
    for (int i = 0; i < 2 * P + 2; i++) begin
      @(negedge clk);
      if (drive[0] && !pa) begin
        if (ta0 < 0) ta0 = i; else if (ta1 < 0) ta1 = i;
      end
      if (ta0 >= 0 && ta1 < 0 && drive[0]) hi_a++;
      if (ta0 >= 0 && tb0 < 0 && drive[2] && i > ta0) tb0 = i;
      pa = drive[0];
    end
    chk("R1 period spacing", 8'(ta1 - ta0), 8'(P));
    chk("R2 B offset", 8'(tb0 - ta0), 8'(O));
    chk("R3 one pulse per period", 8'(hi_a), 8'd1);

    // directed: enable gap delays the next start (R9)
    pa = drive[0];
    t = 0;
    while (!(drive[0] && !pa)) begin pa = drive[0]; @(negedge clk); end
    cyc(5);
    enable = 1'b0;
    for (int i = 0; i < 13; i++) begin
      chk("R9 drive off when disabled", {4'b0, drive}, 8'h00);
      @(negedge clk);
    end
    enable = 1'b1;
    t = 18;
    pa = drive[0];
    while (!(drive[0] && !pa)) begin pa = drive[0]; @(negedge clk); t++; end
    chk("R9 start delayed by gap", 8'(t), 8'(P + 13));

    // overheat while disabled has no effect (R9)
    enable = 1'b0;
    ovh_in = 1'b1; cyc(1); ovh_in = 1'b0;
    cyc(4);
    enable = 1'b1;
    cyc(3);
    chk("R9 overheat ignored when disabled", {6'b0, fault_code}, 8'h00);

    // blanking boundary (R5 / R6)
    cmp_a = 1'b0; cmp_b = 1'b0; phase_req = 4'b1111;
    wait_cnt(B - 2);
    ovc_in = 1'b1; cyc(1); ovc_in = 1'b0;
    cyc(4);
    chk("R5 last blanked cycle", {7'b0, fault_n}, 8'h01);
    wait_cnt(O);
    ovc_in = 1'b1; cyc(1); ovc_in = 1'b0;
    cyc(4);
    chk("R5 blanked on B start", {7'b0, fault_n}, 8'h01);
    wait_cnt(B - 1);
    ovc_in = 1'b1; cyc(1); ovc_in = 1'b0;
    cyc(4);
    chk("R6 overcurrent latched", {7'b0, fault_n}, 8'h00);
    chk("R6 overcurrent code", {6'b0, fault_code}, 8'h01);
    chk("R6 drives off", {4'b0, drive}, 8'h00);

    // overheat priority (R7) then clear (R8)
    ovh_in = 1'b1; cyc(1); ovh_in = 1'b0;
    cyc(4);
    chk("R7 overheat wins", {6'b0, fault_code}, 8'h02);
    pulse_reset_req(6);
    chk("R8 cleared after release", {6'b0, fault_code}, 8'h00);
    ovh_in = 1'b1; cyc(1); ovh_in = 1'b0;
    cyc(4);
    chk("R7 overheat alone", {6'b0, fault_code}, 8'h02);
    chk("R7 drives off", {4'b0, drive}, 8'h00);
    cmp_on = 1'b0;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    chk("R8 power-on reset clears", {7'b0, fault_n}, 8'h01);
    cmp_on = 1'b1;

    // random run with rare faults and resets
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) phase_req = 4'($urandom);
      cmp_a = ($urandom_range(0, 9) == 0);
      cmp_b = ($urandom_range(0, 9) == 0);
      enable = ($urandom_range(0, 29) != 0);
      ovc_in = ($urandom_range(0, 199) == 0);
      ovh_in = ($urandom_range(0, 799) == 0);
      reset_req_n = ($urandom_range(0, 99) != 0);
    end
    cyc(2);
    finish_run();
  end
endmodule